// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block computes and checks a cyclic redundancy code one bit per clock. The degree N and the generator polynomial are parameters fixed at build time. The x^N term is implied. The parameter holds the N lower coefficients, from x^(N-1) down to x^0.

A single mode input, `calc_en`, selects between two uses of the same N-bit register.

- **Compute/test mode** (`calc_en` = 1): each incoming bit is folded directly into the division feedback. After the last message bit, the register already holds the remainder of x^N·M(x) divided by P(x). No trailing zero shifts are needed.
- **Shift-out mode** (`calc_en` = 0): the register shifts toward its MSB with no feedback. The code appears on `dout`, most significant bit first, over N clocks.

To check a received block, the message and its code are fed in compute/test mode. A zero remainder, reported on `data_ok`, means the block is accepted. A synchronous `clr` empties the register before each block.

Top module: `serial_crc_engine`

## Requirements
- R1: When `clr` is high at a clock edge, the register becomes all zeros, so `data_ok` reads 1 afterwards and a following shift-out emits N zero bits.
- R2: `clr` wins over shifting: with `clr`=1, `calc_en`=1 and `din`=1 at the same edge, the register still ends all zero.
- R3: With `calc_en`=1 for k clocks on a k-bit message presented MSB first, the register afterwards holds the remainder of x^N·M(x) modulo P(x), with no extra shifts.
- R4: With `calc_en`=0, `dout` shows the register MSB, and each clock shifts the register one place toward the MSB with a 0 entering stage 0 and no feedback. N clocks deliver the whole code MSB first and leave the register zero.
- R5: While `calc_en`=1, `dout` is 0.
- R6: `data_ok` is 1 exactly when the register is all zeros. After k+N clocks of a message followed by its correct code in compute/test mode, it reads 1.
- R7: A block with any single flipped bit, fed for k+N clocks in compute/test mode, leaves `data_ok` at 0.
- R8: With P=1101 (N=3, parameter 3'b101), message 1011011 yields code 001. With P=11001 (N=4, parameter 4'b1001), message 110011 yields code 1001.
- R9: The degree-16 polynomials x^16+x^15+x^2+1 (parameter 16'h8005) and x^16+x^12+x^5+1 (parameter 16'h1021) are selectable by parameter and produce the remainder defined in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear of the register, active high |
| din | input | 1 | Serial message or block bit, MSB first |
| calc_en | input | 1 | 1: compute/test with feedback; 0: shift out without feedback |
| dout | output | 1 | Serial code output (register MSB in shift-out mode, 0 otherwise) |
| data_ok | output | 1 | High when the register holds all zeros |

## Verification
A wrong feedback tap or a wrong entry point for the incoming bit corrupts the register silently during compute/test mode. The fault first becomes visible on `dout`, in the N clocks after the mode drops to 0, as a wrong code bit. For a received block, it shows on `data_ok` right after the last bit. A shift path that keeps feedback in shift-out mode shows up within N clocks, as a nonzero bit trailing the code or as `data_ok` staying low. A clear that loses to the shift shows on the next edge as `data_ok` low.

// File: rtl/crc_pkg.sv
package crc_pkg;
  // Lower coefficients of common generators (x^N term implied)
  localparam logic [15:0] POLY16_A = 16'h8005; // x^16+x^15+x^2+1
  localparam logic [15:0] POLY16_B = 16'h1021; // x^16+x^12+x^5+1

  typedef enum logic {
    MODE_SHIFT_OUT = 1'b0,
    MODE_CALC      = 1'b1
  } crc_mode_e;
endpackage

// File: rtl/crc_shift_core.sv
module crc_shift_core #(
  parameter int          CRC_W = 3,
  parameter logic [CRC_W-1:0] POLY = 3'b101
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             din,
  input  logic             calc_en,
  output logic [CRC_W-1:0] q
);
  import crc_pkg::*;
  localparam int MSB = CRC_W - 1;

  logic             fb;
  logic [CRC_W-1:0] nxt;

  assign fb = (crc_mode_e'(calc_en) == MODE_CALC) ? (din ^ q[MSB]) : 1'b0;

  for (genvar i = 0; i < CRC_W; i++) begin : g_stage
    if (i == 0) begin : g_lsb
      if (POLY[0]) begin : g_tap
        assign nxt[0] = fb;
      end else begin : g_notap
        assign nxt[0] = 1'b0;
      end
    end else begin : g_mid
      if (POLY[i]) begin : g_tap
        assign nxt[i] = q[i-1] ^ fb;
      end else begin : g_notap
        assign nxt[i] = q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) q <= '0;
    else     q <= nxt;
  end

  // R4
  shift_nofb_chk: assert property (@(posedge clk) disable iff (clr)
    !calc_en |=> (q[MSB:1] == $past(q[MSB-1:0])) && (q[0] == 1'b0));

  // R3
  calc_zero_fb_chk: assert property (@(posedge clk) disable iff (clr)
    (calc_en && !din && !q[MSB]) |=> (q == {$past(q[MSB-1:0]), 1'b0}));
endmodule

// File: rtl/crc_zero_detect.sv
module crc_zero_detect #(
  parameter int CRC_W = 3
) (
  input  logic [CRC_W-1:0] q,
  output logic             is_zero
);
  assign is_zero = ~|q;
endmodule

// File: rtl/crc_dout_sel.sv
module crc_dout_sel (
  input  logic calc_en,
  input  logic msb,
  output logic dout
);
  import crc_pkg::*;
  assign dout = (crc_mode_e'(calc_en) == MODE_CALC) ? 1'b0 : msb;
endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine #(
  parameter int               CRC_W = 3,
  parameter logic [CRC_W-1:0] POLY  = 3'b101
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  input  logic calc_en,
  output logic dout,
  output logic data_ok
);
  logic [CRC_W-1:0] crc_q;

  crc_shift_core #(.CRC_W(CRC_W), .POLY(POLY)) core_i (
    .clk(clk), .clr(clr), .din(din), .calc_en(calc_en), .q(crc_q)
  );

  crc_zero_detect #(.CRC_W(CRC_W)) zero_i (
    .q(crc_q), .is_zero(data_ok)
  );

  crc_dout_sel dsel_i (
    .calc_en(calc_en), .msb(crc_q[CRC_W-1]), .dout(dout)
  );

  // R1 R2
  clr_empties_chk: assert property (@(posedge clk) clr |=> data_ok);

  // R5
  dout_quiet_chk: assert property (@(posedge clk) disable iff (clr)
    calc_en |-> !dout);

  // R6
  zero_stays_chk: assert property (@(posedge clk) disable iff (clr)
    (data_ok && !calc_en) |=> data_ok);
endmodule

// File: tb/serial_crc_engine_tb_top.sv
module serial_crc_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic clr_s [NUM];
  logic din_s [NUM];
  logic cal_s [NUM];
  logic dout_s[NUM];
  logic ok_s  [NUM];

  int checks = 0;
  int errors = 0;

  serial_crc_engine #(.CRC_W(3), .POLY(3'b101)) dut_i (
    .clk(clk), .clr(clr_s[0]), .din(din_s[0]), .calc_en(cal_s[0]),
    .dout(dout_s[0]), .data_ok(ok_s[0]));
  serial_crc_engine #(.CRC_W(4), .POLY(4'b1001)) dut4_i (
    .clk(clk), .clr(clr_s[1]), .din(din_s[1]), .calc_en(cal_s[1]),
    .dout(dout_s[1]), .data_ok(ok_s[1]));
  serial_crc_engine #(.CRC_W(16), .POLY(16'h8005)) dut16a_i (
    .clk(clk), .clr(clr_s[2]), .din(din_s[2]), .calc_en(cal_s[2]),
    .dout(dout_s[2]), .data_ok(ok_s[2]));
  serial_crc_engine #(.CRC_W(16), .POLY(16'h1021)) dut16b_i (
    .clk(clk), .clr(clr_s[3]), .din(din_s[3]), .calc_en(cal_s[3]),
    .dout(dout_s[3]), .data_ok(ok_s[3]));

  function automatic logic [15:0] ref_crc(input logic [63:0] msg, input int k,
                                          input int n, input logic [15:0] poly);
    logic [15:0] rem = '0;
    logic [15:0] mask = 16'((32'd1 << n) - 1);
    for (int i = 0; i < k + n; i++) begin
      logic b   = (i < k) ? msg[k-1-i] : 1'b0;
      logic top = rem[n-1];
      rem = ((rem << 1) | {15'd0, b}) & mask;
      if (top) rem = rem ^ (poly & mask);
    end
    return rem;
  endfunction

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_clear(input int idx);
    clr_s[idx] = 1'b1; cal_s[idx] = 1'b1; din_s[idx] = 1'b0;
    tick();
    clr_s[idx] = 1'b0;
  endtask

  // R3 R4 R5: feed message, shift out code and compare, then confirm zero fill
  task automatic gen_test(input int idx, input logic [63:0] msg, input int k,
                          input int n, input logic [15:0] poly, input string tag);
    logic [15:0] exp = ref_crc(msg, k, n, poly);
    logic [15:0] got = '0;
    bit dout_bad = 0;
    do_clear(idx);
    cal_s[idx] = 1'b1;
    for (int i = 0; i < k; i++) begin
      din_s[idx] = msg[k-1-i];
      #1;
      if (dout_s[idx] !== 1'b0) dout_bad = 1;
      tick();
      if (dout_s[idx] !== 1'b0) dout_bad = 1;
    end
    chk(!dout_bad, "R5 dout quiet in calc mode", dout_bad, 0);
    cal_s[idx] = 1'b0; din_s[idx] = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      got = {got[14:0], dout_s[idx]};
      tick();
    end
    chk(got == exp, tag, got, exp);
    chk(ok_s[idx] === 1'b1, "R4 register empty after N shift-out clocks", ok_s[idx], 1);
    cal_s[idx] = 1'b1;
  endtask

  // R6 R7: feed message plus code (optionally flipped bit) and check data_ok
  task automatic chk_test(input int idx, input logic [63:0] msg, input int k,
                          input int n, input logic [15:0] poly, input int flip);
    logic [15:0] code = ref_crc(msg, k, n, poly);
    do_clear(idx);
    cal_s[idx] = 1'b1;
    for (int i = 0; i < k + n; i++) begin
      logic b = (i < k) ? msg[k-1-i] : code[n-1-(i-k)];
      if (i == flip) b = ~b;
      din_s[idx] = b;
      tick();
    end
    if (flip < 0) chk(ok_s[idx] === 1'b1, "R6 valid block accepted", ok_s[idx], 1);
    else          chk(ok_s[idx] === 1'b0, "R7 corrupted block rejected", ok_s[idx], 0);
  endtask

  // R1 R2: clear while feeding ones in calc mode
  task automatic clr_test(input int idx, input int n);
    bit any_one = 0;
    cal_s[idx] = 1'b1; din_s[idx] = 1'b1; clr_s[idx] = 1'b0;
    tick(); tick();
    chk(ok_s[idx] === 1'b0, "R6 nonzero register flags not ok", ok_s[idx], 0);
    clr_s[idx] = 1'b1;
    tick();
    clr_s[idx] = 1'b0;
    chk(ok_s[idx] === 1'b1, "R2 clear wins over calc shift", ok_s[idx], 1);
    cal_s[idx] = 1'b0; din_s[idx] = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      if (dout_s[idx] !== 1'b0) any_one = 1;
      tick();
    end
    chk(!any_one, "R1 cleared register shifts out zeros", any_one, 0);
    cal_s[idx] = 1'b1;
  endtask

  initial begin
    for (int j = 0; j < NUM; j++) begin
      clr_s[j] = 1'b1; din_s[j] = 1'b0; cal_s[j] = 1'b1;
    end
    @(negedge clk); tick();
    for (int j = 0; j < NUM; j++) clr_s[j] = 1'b0;
    chk(ok_s[0] === 1'b1 && ok_s[3] === 1'b1, "R1 reset state data_ok", ok_s[0], 1);
    chk(dout_s[0] === 1'b0, "R5 reset dout low", dout_s[0], 0);

    // R8 known vectors, checked on bench model first
    chk(ref_crc(64'b1011011, 7, 3, 16'h5) == 16'h1, "R8 model N3", ref_crc(64'b1011011, 7, 3, 16'h5), 1);
    chk(ref_crc(64'b110011, 6, 4, 16'h9) == 16'h9, "R8 model N4", ref_crc(64'b110011, 6, 4, 16'h9), 9);
    gen_test(0, 64'b1011011, 7, 3, 16'h5, "R8 N3 code 001");
    gen_test(1, 64'b110011, 6, 4, 16'h9, "R8 N4 code 1001");
    chk_test(0, 64'b1011011, 7, 3, 16'h5, -1);
    chk_test(1, 64'b110011, 6, 4, 16'h9, -1);
    chk_test(0, 64'b1011011, 7, 3, 16'h5, 2);
    chk_test(1, 64'b110011, 6, 4, 16'h9, 9);

    // R3 other patterns
    gen_test(0, 64'b1, 1, 3, 16'h5, "R3 single one bit");
    gen_test(1, 64'hFF, 8, 4, 16'h9, "R3 all ones byte");
    gen_test(0, 64'h0, 5, 3, 16'h5, "R3 all zero message");

    // R9 degree-16 generators
    gen_test(2, 64'h1234_5678, 32, 16, 16'h8005, "R9 poly 8005");
    gen_test(3, 64'h1234_5678, 32, 16, 16'h1021, "R9 poly 1021");
    gen_test(3, 64'hDEAD_BEEF_0F0F, 48, 16, 16'h1021, "R9 poly 1021 long");
    chk_test(2, 64'hCAFE, 16, 16, 16'h8005, -1);
    chk_test(3, 64'hCAFE, 16, 16, 16'h1021, -1);
    chk_test(3, 64'hCAFE, 16, 16, 16'h1021, 0);
    chk_test(2, 64'hCAFE, 16, 16, 16'h8005, 31);

    clr_test(0, 3);
    clr_test(2, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule